// File: doc/BRIEF.md
# Coprocessor Trap Entry and Exception Return Sequencer

This block is the part of a 32-bit CPU core that carries out, over several cycles, two stack sequences. The first is trap entry for coprocessor faults. One kind of trap is raised when a coprocessor instruction names a coprocessor that is not fitted. The other is a deferred error trap: a coprocessor error is only recorded when it occurs, and the trap is taken on the next coprocessor instruction that uses the coprocessor. Trap entry pushes the status word and the next-instruction address onto the kernel stack and clears the stack-select bit. It then fetches the handler address from a vector slot that sits at a fixed offset above a relocatable vector base. The second sequence is the return-from-exception instruction. It pops the program counter and then the status word through the general stack pointer.

The decode stage presents a coprocessor instruction or a return instruction as a one-cycle request, together with the architectural values the sequence needs. The block answers with an acknowledge in the next cycle. It performs every memory access over a single request/ready bus. When the sequence ends it presents the new program counter, status word and stack pointer with a one-cycle done pulse. A return issued while the stack-select bit is set performs no memory access and raises an illegal-return pulse instead.

Top module: `trap_seq_unit`

## Requirements
- R1: On trap entry the block writes the status word to kernel stack pointer minus 4, then writes the next-instruction address to kernel stack pointer minus 8, in that order. It reports the kernel stack pointer minus 8 as the new stack pointer.
- R2: The status word reported after trap entry equals the sampled status word with the stack-select bit (bit 5) cleared. The word stored on the stack keeps that bit unchanged.
- R3: A coprocessor instruction whose coprocessor is not present causes a third access, a read at vector base + 0x3E0. The word read becomes the new program counter.
- R4: A coprocessor fault pulse sets a pending flag. The next coprocessor instruction to a present coprocessor then traps with a vector read at vector base + 0x3DC, and the trap clears the flag. A fault that arrives in the same cycle as an accepted instruction does not act on that instruction.
- R5: A coprocessor instruction to a present coprocessor, with no fault pending, is acknowledged but performs no memory access and gives no done pulse.
- R6: A return with the stack-select bit at 0 reads the program counter from the general stack pointer, then the status word from general stack pointer + 4. It reports general stack pointer + 8 as the new stack pointer.
- R7: A return with the stack-select bit at 1 performs no memory access and gives no done pulse. It pulses the illegal-return output for one cycle, one cycle after the request.
- R8: While a bus request waits for ready, the address, write enable and write data stay constant, and each completed access moves the sequence to its next step.
- R9: The done output is a one-cycle pulse in the cycle after the final access completes. The new program counter, status word and stack pointer are valid in that cycle.
- R10: A request in idle is acknowledged one cycle later. Requests that arrive while a sequence runs are neither acknowledged nor executed. A coprocessor instruction takes priority over a return presented in the same cycle.
- R11: A missing coprocessor takes priority over a pending fault. The fault stays pending and traps on the next coprocessor instruction to a present coprocessor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cop_req | input | 1 | Coprocessor instruction issued (one-cycle request) |
| cop_present | input | 1 | The targeted coprocessor is fitted |
| cop_fault | input | 1 | Coprocessor reports an error (recorded, trapped later) |
| ret_req | input | 1 | Return-from-exception instruction issued |
| stat_i | input | 32 | Current processor status word |
| vbase_i | input | 32 | Vector table base |
| ksp_i | input | 32 | Kernel stack pointer |
| gsp_i | input | 32 | General stack pointer used by the return |
| next_pc_i | input | 32 | Address of the next instruction |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Memory access completes this cycle |
| req_ack | output | 1 | Request accepted (one cycle after request) |
| done_o | output | 1 | Sequence finished, new values valid |
| ret_illegal_o | output | 1 | Return refused because the stack-select bit was set |
| new_pc_o | output | 32 | New program counter |
| new_stat_o | output | 32 | New status word |
| new_sp_o | output | 32 | New stack pointer value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |

## Verification
Recording a coprocessor fault and accepting a coprocessor instruction can fall in the same cycle. The bench raises the fault pulse in exactly the cycle a present-coprocessor instruction is sampled. It judges that this instruction is acknowledged with no memory access, and that the following coprocessor instruction takes the error trap through vector base + 0x3DC. A second overlap is a return presented together with a missing-coprocessor instruction; there the bench checks that a three-access trap entry runs and that no pop runs.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_STAT,
        ST_PUSH_PC,
        ST_VEC_RD,
        ST_POP_PC,
        ST_POP_STAT
    } seq_state_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_PASS,
        EV_NOCP,
        EV_CPERR,
        EV_RET,
        EV_BADRET
    } ev_kind_e;

endpackage

// File: rtl/trap_ev_decode.sv
module trap_ev_decode
    import trap_seq_pkg::*;
(
    input  logic     idle,
    input  logic     cop_req,
    input  logic     cop_present,
    input  logic     err_pend,
    input  logic     ret_req,
    input  logic     stack_sel,
    output ev_kind_e kind
);
    // Coprocessor instructions win over returns; a missing unit wins over a pending fault.
    always_comb begin
        kind = EV_NONE;
        if (idle) begin
            if (cop_req) begin
                if (!cop_present) begin
                    kind = EV_NOCP;
                end else if (err_pend) begin
                    kind = EV_CPERR;
                end else begin
                    kind = EV_PASS;
                end
            end else if (ret_req) begin
                kind = stack_sel ? EV_BADRET : EV_RET;
            end
        end
    end
endmodule

// File: rtl/trap_err_latch.sv
module trap_err_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    input  logic consume,
    output logic pend
);
    logic pend_d, pend_q;

    // A new fault outranks the clear of an older one.
    always_comb begin
        pend_d = (pend_q & ~consume) | fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/trap_vec_addr.sv
module trap_vec_addr #(
    parameter int W         = 32,
    parameter int OFF_NOCP  = 'h3E0,
    parameter int OFF_CPERR = 'h3DC
) (
    input  logic [W-1:0] base,
    input  logic         is_err,
    output logic [W-1:0] addr
);
    localparam logic [W-1:0] OffNocp  = W'(OFF_NOCP);
    localparam logic [W-1:0] OffCperr = W'(OFF_CPERR);

    assign addr = base + (is_err ? OffCperr : OffNocp);
endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
    import trap_seq_pkg::*;
#(
    parameter int W     = 32,
    parameter int S_BIT = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ev_kind_e     kind,
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] vbase_i,
    input  logic [W-1:0] ksp_i,
    input  logic [W-1:0] gsp_i,
    input  logic [W-1:0] next_pc_i,
    input  logic [W-1:0] vec_addr,
    output logic [W-1:0] vec_base,
    output logic         vec_is_err,
    output logic         idle,
    output logic         entry_flag,
    output logic         req_ack,
    output logic         done_o,
    output logic         ret_illegal_o,
    output logic [W-1:0] new_pc_o,
    output logic [W-1:0] new_stat_o,
    output logic [W-1:0] new_sp_o,
    input  logic [W-1:0] mem_rdata,
    input  logic         mem_ready,
    output logic         mem_req,
    output logic         mem_we,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata
);
    localparam logic [W-1:0] WordB  = W'(4);
    localparam logic [W-1:0] PairB  = W'(8);
    localparam logic [W-1:0] SelMsk = W'(1) << S_BIT;

    typedef struct packed {
        seq_state_e   st;
        logic [W-1:0] sp;
        logic [W-1:0] stat;
        logic [W-1:0] npc;
        logic [W-1:0] vbase;
        logic         vec_err;
        logic         entry;
        logic [W-1:0] pc_out;
        logic [W-1:0] stat_out;
        logic [W-1:0] sp_out;
        logic         done;
        logic         ack;
        logic         illegal;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.ack     = 1'b0;
        r_d.illegal = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (kind != EV_NONE) begin
                    r_d.ack = 1'b1;
                end
                case (kind)
                    EV_NOCP, EV_CPERR: begin
                        r_d.st      = ST_PUSH_STAT;
                        r_d.sp      = ksp_i;
                        r_d.stat    = stat_i;
                        r_d.npc     = next_pc_i;
                        r_d.vbase   = vbase_i;
                        r_d.vec_err = (kind == EV_CPERR);
                        r_d.entry   = 1'b1;
                    end
                    EV_RET: begin
                        r_d.st    = ST_POP_PC;
                        r_d.sp    = gsp_i;
                        r_d.entry = 1'b0;
                    end
                    EV_BADRET: begin
                        r_d.illegal = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_PUSH_STAT: begin
                if (mem_ready) begin
                    r_d.st = ST_PUSH_PC;
                end
            end
            ST_PUSH_PC: begin
                if (mem_ready) begin
                    r_d.st = ST_VEC_RD;
                end
            end
            ST_VEC_RD: begin
                if (mem_ready) begin
                    r_d.st       = ST_IDLE;
                    r_d.pc_out   = mem_rdata;
                    r_d.stat_out = r_q.stat & ~SelMsk;
                    r_d.sp_out   = r_q.sp - PairB;
                    r_d.done     = 1'b1;
                end
            end
            ST_POP_PC: begin
                if (mem_ready) begin
                    r_d.st     = ST_POP_STAT;
                    r_d.pc_out = mem_rdata;
                end
            end
            ST_POP_STAT: begin
                if (mem_ready) begin
                    r_d.st       = ST_IDLE;
                    r_d.stat_out = mem_rdata;
                    r_d.sp_out   = r_q.sp + PairB;
                    r_d.done     = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Bus drive depends only on registered state, so it holds while ready is low.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (r_q.st)
            ST_PUSH_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - WordB;
                mem_wdata = r_q.stat;
            end
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - PairB;
                mem_wdata = r_q.npc;
            end
            ST_VEC_RD: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr;
            end
            ST_POP_PC: begin
                mem_req  = 1'b1;
                mem_addr = r_q.sp;
            end
            ST_POP_STAT: begin
                mem_req  = 1'b1;
                mem_addr = r_q.sp + WordB;
            end
            default: ;
        endcase
    end

    assign vec_base      = r_q.vbase;
    assign vec_is_err    = r_q.vec_err;
    assign idle          = (r_q.st == ST_IDLE);
    assign entry_flag    = r_q.entry;
    assign req_ack       = r_q.ack;
    assign done_o        = r_q.done;
    assign ret_illegal_o = r_q.illegal;
    assign new_pc_o      = r_q.pc_out;
    assign new_stat_o    = r_q.stat_out;
    assign new_sp_o      = r_q.sp_out;
endmodule

// File: rtl/trap_seq_unit.sv
module trap_seq_unit
    import trap_seq_pkg::*;
#(
    parameter int W         = 32,
    parameter int S_BIT     = 5,
    parameter int OFF_NOCP  = 'h3E0,
    parameter int OFF_CPERR = 'h3DC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cop_req,
    input  logic         cop_present,
    input  logic         cop_fault,
    input  logic         ret_req,
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] vbase_i,
    input  logic [W-1:0] ksp_i,
    input  logic [W-1:0] gsp_i,
    input  logic [W-1:0] next_pc_i,
    input  logic [W-1:0] mem_rdata,
    input  logic         mem_ready,
    output logic         req_ack,
    output logic         done_o,
    output logic         ret_illegal_o,
    output logic [W-1:0] new_pc_o,
    output logic [W-1:0] new_stat_o,
    output logic [W-1:0] new_sp_o,
    output logic         mem_req,
    output logic         mem_we,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata
);
    ev_kind_e     kind;
    logic         idle;
    logic         entry_flag;
    logic         err_pend;
    logic [W-1:0] vec_base;
    logic         vec_is_err;
    logic [W-1:0] vec_addr;

    trap_err_latch u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault   (cop_fault),
        .consume (kind == EV_CPERR),
        .pend    (err_pend)
    );

    trap_ev_decode u_dec (
        .idle        (idle),
        .cop_req     (cop_req),
        .cop_present (cop_present),
        .err_pend    (err_pend),
        .ret_req     (ret_req),
        .stack_sel   (stat_i[S_BIT]),
        .kind        (kind)
    );

    trap_vec_addr #(.W(W), .OFF_NOCP(OFF_NOCP), .OFF_CPERR(OFF_CPERR)) u_vec (
        .base   (vec_base),
        .is_err (vec_is_err),
        .addr   (vec_addr)
    );

    trap_seq_fsm #(.W(W), .S_BIT(S_BIT)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .kind          (kind),
        .stat_i        (stat_i),
        .vbase_i       (vbase_i),
        .ksp_i         (ksp_i),
        .gsp_i         (gsp_i),
        .next_pc_i     (next_pc_i),
        .vec_addr      (vec_addr),
        .vec_base      (vec_base),
        .vec_is_err    (vec_is_err),
        .idle          (idle),
        .entry_flag    (entry_flag),
        .req_ack       (req_ack),
        .done_o        (done_o),
        .ret_illegal_o (ret_illegal_o),
        .new_pc_o      (new_pc_o),
        .new_stat_o    (new_stat_o),
        .new_sp_o      (new_sp_o),
        .mem_rdata     (mem_rdata),
        .mem_ready     (mem_ready),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata)
    );
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk #(
    parameter int W     = 32,
    parameter int S_BIT = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mem_req,
    input logic         mem_we,
    input logic [W-1:0] mem_addr,
    input logic [W-1:0] mem_wdata,
    input logic         mem_ready,
    input logic         done_o,
    input logic         req_ack,
    input logic         ret_illegal_o,
    input logic [W-1:0] new_stat_o,
    input logic         idle,
    input logic         entry_flag
);
    assert_bus_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(mem_req && mem_ready));

    assert_bad_ret_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ret_illegal_o |-> !mem_req && !done_o);

    assert_ack_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> $past(idle));

    assert_sel_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && entry_flag |-> !new_stat_o[S_BIT]);
endmodule

bind trap_seq_unit trap_seq_chk #(.W(W), .S_BIT(S_BIT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ready     (mem_ready),
    .done_o        (done_o),
    .req_ack       (req_ack),
    .ret_illegal_o (ret_illegal_o),
    .new_stat_o    (new_stat_o),
    .idle          (idle),
    .entry_flag    (entry_flag)
);

// File: tb/sim_trap_seq_unit.sv
module sim_trap_seq_unit;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic         cop_req = 0, cop_present = 0, cop_fault = 0, ret_req = 0;
    logic [W-1:0] stat_i = 0, vbase_i = 0, ksp_i = 0, gsp_i = 0, next_pc_i = 0;
    logic [W-1:0] mem_rdata;
    logic         mem_ready;
    logic         req_ack, done_o, ret_illegal_o, mem_req, mem_we;
    logic [W-1:0] new_pc_o, new_stat_o, new_sp_o, mem_addr, mem_wdata;

    trap_seq_unit u0 (.*);

    // Memory model: 256 words, byte address bits 9:2, configurable wait states.
    logic [W-1:0] mem [256];
    int lat = 0;
    int wcnt = 0;
    assign mem_ready = mem_req && (wcnt >= lat);
    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) begin
        if (!mem_req || mem_ready) wcnt <= 0;
        else wcnt <= wcnt + 1;
    end

    int n_acc = 0, n_done = 0, n_ill = 0;
    logic [W-1:0] log_addr [8];
    logic         log_we   [8];
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_ready) begin
                log_addr[n_acc % 8] = mem_addr;
                log_we[n_acc % 8]   = mem_we;
                if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
                n_acc++;
            end
            if (done_o) n_done++;
            if (ret_illegal_o) n_ill++;
        end
    end

    int checks = 0, errors = 0;
    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    logic ack_seen;
    task automatic issue(input logic cop, input logic pres, input logic ret, input logic flt,
                         input logic [W-1:0] st, input logic [W-1:0] sp, input logic [W-1:0] vb,
                         input logic [W-1:0] npc);
        @(negedge clk);
        cop_req = cop; cop_present = pres; ret_req = ret; cop_fault = flt;
        stat_i = st; ksp_i = sp; gsp_i = sp; vbase_i = vb; next_pc_i = npc;
        @(negedge clk);
        ack_seen = req_ack;
        cop_req = 0; ret_req = 0; cop_fault = 0;
    endtask

    task automatic wait_done(input int base_done);
        for (int i = 0; i < 60; i++) begin
            if (n_done > base_done) break;
            @(negedge clk);
        end
    endtask

    // Full trap-entry check: kind_err selects the 0x3DC slot.
    task automatic entry_case(input string tag, input logic kind_err, input logic [W-1:0] st,
                              input logic [W-1:0] sp, input logic [W-1:0] vb, input logic [W-1:0] npc,
                              input logic pres);
        int a0, d0;
        logic [W-1:0] va, hw;
        va = vb + (kind_err ? 32'h3DC : 32'h3E0);
        hw = 32'hC0DE_0000 ^ va;
        mem[va[9:2]] = hw;
        a0 = n_acc; d0 = n_done;
        issue(1'b1, pres, 1'b0, 1'b0, st, sp, vb, npc);
        chk({tag, " R10 ack"}, {31'b0, ack_seen}, 1);
        wait_done(d0);
        chk({tag, " R9 done"}, n_done - d0, 1);
        chk({tag, " R1 accesses"}, n_acc - a0, 3);
        chk({tag, " R1 stat addr"}, log_addr[a0 % 8], sp - 4);
        chk({tag, " R1 pc addr"}, log_addr[(a0 + 1) % 8], sp - 8);
        chk({tag, " R3 vec addr"}, log_addr[(a0 + 2) % 8], va);
        chk({tag, " R1 stored stat"}, mem[(sp - 32'd4) >> 2 & 32'hFF], st);
        chk({tag, " R1 stored pc"}, mem[(sp - 32'd8) >> 2 & 32'hFF], npc);
        chk({tag, " R3 new pc"}, new_pc_o, hw);
        chk({tag, " R2 new stat"}, new_stat_o, st & ~32'h20);
        chk({tag, " R1 new sp"}, new_sp_o, sp - 8);
        @(negedge clk);
        chk({tag, " R9 pulse"}, {31'b0, done_o}, 0);
    endtask

    task automatic ret_case(input string tag, input logic [W-1:0] sp, input logic [W-1:0] pcw,
                            input logic [W-1:0] stw);
        int a0, d0;
        mem[sp[9:2]] = pcw;
        mem[(sp + 32'd4) >> 2 & 32'hFF] = stw;
        a0 = n_acc; d0 = n_done;
        issue(1'b0, 1'b0, 1'b1, 1'b0, 32'h0, sp, 32'h0, 32'h0);
        chk({tag, " R10 ack"}, {31'b0, ack_seen}, 1);
        wait_done(d0);
        chk({tag, " R6 accesses"}, n_acc - a0, 2);
        chk({tag, " R6 pc addr"}, log_addr[a0 % 8], sp);
        chk({tag, " R6 stat addr"}, log_addr[(a0 + 1) % 8], sp + 4);
        chk({tag, " R6 new pc"}, new_pc_o, pcw);
        chk({tag, " R6 new stat"}, new_stat_o, stw);
        chk({tag, " R6 new sp"}, new_sp_o, sp + 8);
    endtask

    typedef struct packed {
        logic         is_ret;
        logic [31:0]  st;
        logic [31:0]  sp;
        logic [31:0]  vb;
        logic [31:0]  npc;
        logic [3:0]   wait_cyc;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 32'h0000_00F0, 32'h0000_0200, 32'h0000_0000, 32'h1234_5678, 4'd0},
        '{1'b0, 32'h8000_0020, 32'h0000_0180, 32'h0000_0040, 32'hDEAD_BEE0, 4'd2},
        '{1'b1, 32'h0000_0000, 32'h0000_0100, 32'h5555_AAAA, 32'h0BAD_F00D, 4'd0},
        '{1'b0, 32'hFFFF_FFFF, 32'h0000_0300, 32'h0000_0080, 32'h0000_4444, 4'd3},
        '{1'b1, 32'h0000_0000, 32'h0000_0140, 32'hFFFF_FFDF, 32'h0000_2468, 4'd1},
        '{1'b0, 32'h0000_0000, 32'h0000_0208, 32'h0000_0000, 32'h0000_0004, 4'd1}
    };

    initial begin
        int a0, d0, i0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // Reset state
        chk("R9 reset done", {31'b0, done_o}, 0);
        chk("R8 reset req", {31'b0, mem_req}, 0);
        chk("R10 reset ack", {31'b0, req_ack}, 0);
        chk("R7 reset illegal", {31'b0, ret_illegal_o}, 0);
        rst_n = 1'b1;

        // Vector table: missing-coprocessor entries and returns (for returns vb field is the stored status, npc the stored pc).
        for (int k = 0; k < 6; k++) begin
            lat = int'(VECS[k].wait_cyc);
            if (VECS[k].is_ret)
                ret_case($sformatf("vec%0d", k), VECS[k].sp, VECS[k].npc, VECS[k].vb);
            else
                entry_case($sformatf("vec%0d", k), 1'b0, VECS[k].st, VECS[k].sp, VECS[k].vb, VECS[k].npc, 1'b0);
        end
        lat = 0;

        // R5: present coprocessor, nothing pending: ack only.
        a0 = n_acc; d0 = n_done;
        issue(1'b1, 1'b1, 1'b0, 1'b0, 32'h20, 32'h200, 32'h0, 32'h10);
        chk("R5 ack", {31'b0, ack_seen}, 1);
        repeat (6) @(negedge clk);
        chk("R5 no access", n_acc - a0, 0);
        chk("R5 no done", n_done - d0, 0);

        // R4: fault in the same cycle as an accepted instruction does not act on it.
        a0 = n_acc;
        issue(1'b1, 1'b1, 1'b0, 1'b1, 32'h0, 32'h200, 32'h0, 32'h10);
        repeat (6) @(negedge clk);
        chk("R4 same-cycle fault no trap", n_acc - a0, 0);
        entry_case("R4 deferred", 1'b1, 32'h0000_0021, 32'h01C0, 32'h0, 32'h0000_0A00, 1'b1);
        a0 = n_acc;
        issue(1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h200, 32'h0, 32'h10);
        repeat (6) @(negedge clk);
        chk("R4 pending cleared", n_acc - a0, 0);

        // R11: missing coprocessor outranks a pending fault, which stays pending.
        issue(1'b0, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0, 32'h0, 32'h0);
        entry_case("R11 nocp first", 1'b0, 32'h0000_0033, 32'h0200, 32'h0, 32'h0000_0B00, 1'b0);
        entry_case("R11 error later", 1'b1, 32'h0000_0033, 32'h0200, 32'h40, 32'h0000_0B04, 1'b1);

        // R7: return with stack-select set is refused.
        a0 = n_acc; d0 = n_done; i0 = n_ill;
        issue(1'b0, 1'b0, 1'b1, 1'b0, 32'h20, 32'h100, 32'h0, 32'h0);
        chk("R7 illegal pulse", {31'b0, ret_illegal_o}, 1);
        @(negedge clk);
        chk("R7 pulse ends", {31'b0, ret_illegal_o}, 0);
        repeat (4) @(negedge clk);
        chk("R7 one pulse", n_ill - i0, 1);
        chk("R7 no access", n_acc - a0, 0);
        chk("R7 no done", n_done - d0, 0);

        // R10: cop request and return together: trap entry wins.
        a0 = n_acc; d0 = n_done;
        mem[(32'h3E0) >> 2] = 32'h0000_7770;
        issue(1'b1, 1'b0, 1'b1, 1'b0, 32'h0, 32'h200, 32'h0, 32'h0000_0C00);
        wait_done(d0);
        chk("R10 priority accesses", n_acc - a0, 3);
        chk("R10 priority first is write", {31'b0, log_we[a0 % 8]}, 1);
        chk("R10 priority pc", new_pc_o, 32'h0000_7770);

        // R10: request while busy is ignored.
        lat = 3;
        a0 = n_acc; d0 = n_done;
        issue(1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h200, 32'h0, 32'h0000_0D00);
        repeat (2) @(negedge clk);
        issue(1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 32'h100, 32'h0, 32'h0);
        chk("R10 busy no ack", {31'b0, ack_seen}, 0);
        wait_done(d0);
        repeat (8) @(negedge clk);
        chk("R10 busy accesses", n_acc - a0, 3);
        chk("R10 busy one done", n_done - d0, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule